// File: doc/BRIEF.md
# Operand-Fetch and Write-Back Handshake Unit

This block is a small computation unit that sits between a scoreboard and a two-input arithmetic stage. The unit starts work on a single-cycle issue strobe that carries an operation code. It then asks the scoreboard for each of its two source operands through a separate request/grant pair. The value present on a source bus is captured in the cycle its grant meets its request. When both operands are held, the unit starts its internal ALU and waits for the ALU's valid flag to rise. It latches the result and asks for write-back permission. The write grant moves the result onto the data output, and the unit returns to idle.

A kill input cancels the operation in flight from any state. On the next cycle no requests are outstanding, the unit is idle, and the data output keeps its old value. The internal ALU is a fixed-latency stage that does add, subtract, AND and XOR on 16-bit words, and it exists so that the handshake can be exercised end to end.

Top module: `opnd_result_cu`

## Requirements
- R1: After reset, busy_o is 0, both read requests and the write request are 0, and data_o is 0.
- R2: An issue strobe seen while idle makes busy_o 1 on the next cycle, with both read-request bits (bit 0 = operand A, bit 1 = operand B) set.
- R3: A read request is never high while busy_o is 0, and grants received while idle have no effect.
- R4: In the cycle where rd_gnt_i[i] and rd_req_o[i] are both high, the value on source i (bit 0 takes src_a_i, bit 1 takes src_b_i) is captured as that ALU operand. Values on the source buses in other cycles do not affect the result.
- R5: A read-request bit is low on the cycle after its grant is seen.
- R6: The write request is raised only after both operands are captured and the ALU valid flag has risen. It is never high together with a read request.
- R7: In the cycle after wr_gnt_i and wr_req_o are both high, data_o holds the result, wr_req_o is 0 and busy_o is 0.
- R8: Kill while busy leaves the unit idle on the next cycle, with no read or write request, and data_o unchanged.
- R9: An issue strobe while busy is ignored: the operation code already accepted is kept.
- R10: Operation codes are 0 = A+B, 1 = A-B, 2 = A AND B and 3 = A XOR B, all modulo 2^16.
- R11: Kill while idle has no effect on busy_o, the requests or data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Single-cycle start strobe |
| op_i | input | 2 | Operation code sampled with issue |
| kill_i | input | 1 | Abort the operation in flight |
| src_a_i | input | 16 | Source bus for operand A |
| src_b_i | input | 16 | Source bus for operand B |
| rd_gnt_i | input | 2 | Read grants, one bit per operand |
| wr_gnt_i | input | 1 | Write-back grant |
| rd_req_o | output | 2 | Read requests, one bit per operand |
| wr_req_o | output | 1 | Write-back request |
| busy_o | output | 1 | Unit is holding an operation |
| data_o | output | 16 | Result after write-back |

## Verification
The hardest case to reach is a kill that lands in a chosen phase: between the two operand grants, while the ALU is counting, or while the write request waits for its grant. Seen from the ports, every one of these phases looks like a plain busy unit. The bench sweeps the kill cycle across the whole life of an operation with fixed grant delays, so each phase is hit in turn, and the operation that follows confirms that nothing stale remains. The source buses carry new values every cycle, so a capture in the wrong cycle shows up in the result.

// File: rtl/cu_pkg.sv
package cu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_START = 3'd2,
    ST_WAIT  = 3'd3,
    ST_WRITE = 3'd4
  } cu_state_e;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } cu_op_e;
endpackage

// File: rtl/cu_opnd_reg.sv
module cu_opnd_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_o;
    if (load_i) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_nxt;
  end
endmodule

// File: rtl/cu_alu.sv
module cu_alu #(
  parameter int unsigned W   = 16,
  parameter int unsigned LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          clear_i,
  input  cu_pkg::cu_op_e op_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [W-1:0]  res_o,
  output logic          vld_o
);
  import cu_pkg::*;
  localparam int unsigned CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [W-1:0]  res_nxt, fn;
  logic          vld_nxt;

  always_comb begin
    unique case (op_i)
      OP_ADD:  fn = a_i + b_i;
      OP_SUB:  fn = a_i - b_i;
      OP_AND:  fn = a_i & b_i;
      default: fn = a_i ^ b_i;
    endcase
  end

  always_comb begin
    cnt_nxt = cnt_q;
    res_nxt = res_o;
    vld_nxt = vld_o;
    if (clear_i) begin
      cnt_nxt = '0;
      vld_nxt = 1'b0;
    end else if (start_i) begin
      cnt_nxt = CW'(LAT);
      vld_nxt = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_nxt = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        res_nxt = fn;
        vld_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      res_o <= '0;
      vld_o <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      res_o <= res_nxt;
      vld_o <= vld_nxt;
    end
  end

  // R6
  alu_start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i || clear_i) |=> !vld_o);
endmodule

// File: rtl/cu_ctrl.sv
module cu_ctrl #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic            kill_i,
  input  logic [NSRC-1:0] rd_gnt_i,
  input  logic            wr_gnt_i,
  input  logic            alu_vld_i,
  output logic            busy_o,
  output logic [NSRC-1:0] rd_req_o,
  output logic            wr_req_o,
  output logic [NSRC-1:0] rd_take_o,
  output logic            op_load_o,
  output logic            alu_start_o,
  output logic            alu_clear_o,
  output logic            res_load_o,
  output logic            out_load_o
);
  import cu_pkg::*;

  cu_state_e       st_q, st_nxt;
  logic [NSRC-1:0] rd_nxt, pend;
  logic            wr_nxt, vld_q, vld_rise, kill_act, wr_take;

  assign busy_o   = (st_q != ST_IDLE);
  assign kill_act = kill_i && busy_o;
  assign vld_rise = alu_vld_i && !vld_q;
  assign wr_take  = wr_gnt_i && wr_req_o;
  assign pend     = rd_req_o & ~rd_gnt_i;

  always_comb begin
    st_nxt = st_q;
    rd_nxt = rd_req_o;
    wr_nxt = wr_req_o;
    if (kill_act) begin
      st_nxt = ST_IDLE;
      rd_nxt = '0;
      wr_nxt = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (issue_i) begin
          st_nxt = ST_READ;
          rd_nxt = '1;
        end
        ST_READ: begin
          rd_nxt = pend;
          if (pend == '0) st_nxt = ST_START;
        end
        ST_START: st_nxt = ST_WAIT;
        ST_WAIT: if (vld_rise) begin
          st_nxt = ST_WRITE;
          wr_nxt = 1'b1;
        end
        ST_WRITE: if (wr_take) begin
          st_nxt = ST_IDLE;
          wr_nxt = 1'b0;
        end
        default: st_nxt = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_take_o   = (kill_act || st_q != ST_READ) ? '0 : (rd_gnt_i & rd_req_o);
    op_load_o   = issue_i && (st_q == ST_IDLE);
    alu_start_o = !kill_act && (st_q == ST_START);
    alu_clear_o = kill_act;
    res_load_o  = !kill_act && (st_q == ST_WAIT) && vld_rise;
    out_load_o  = !kill_act && (st_q == ST_WRITE) && wr_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      rd_req_o <= '0;
      wr_req_o <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      st_q     <= st_nxt;
      rd_req_o <= rd_nxt;
      wr_req_o <= wr_nxt;
      vld_q    <= alu_vld_i;
    end
  end

  // R3
  no_idle_rd_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (rd_req_o == '0));

  // R6
  no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> (rd_req_o == '0));

  // R6
  vld_rise_wr_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && vld_rise && !kill_i) |=> wr_req_o);

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_rd_chk
      // R5
      rd_req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_gnt_i[i] && rd_req_o[i]) |=> !rd_req_o[i]);
    end
  endgenerate
endmodule

// File: rtl/opnd_result_cu.sv
module opnd_result_cu #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ALU_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [1:0]        op_i,
  input  logic              kill_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [1:0]        rd_gnt_i,
  input  logic              wr_gnt_i,
  output logic [1:0]        rd_req_o,
  output logic              wr_req_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o
);
  import cu_pkg::*;
  localparam int unsigned NSRC = 2;

  logic [DATA_W-1:0] src   [NSRC];
  logic [DATA_W-1:0] opnd  [NSRC];
  logic [NSRC-1:0]   rd_take;
  logic              op_load, alu_start, alu_clear, res_load, out_load, alu_vld;
  logic [DATA_W-1:0] alu_res, res_q, res_nxt, data_nxt;
  cu_op_e            op_q, op_nxt;

  assign src[0] = src_a_i;
  assign src[1] = src_b_i;

  cu_ctrl #(.NSRC(NSRC)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .kill_i(kill_i),
    .rd_gnt_i(rd_gnt_i), .wr_gnt_i(wr_gnt_i), .alu_vld_i(alu_vld),
    .busy_o(busy_o), .rd_req_o(rd_req_o), .wr_req_o(wr_req_o),
    .rd_take_o(rd_take), .op_load_o(op_load), .alu_start_o(alu_start),
    .alu_clear_o(alu_clear), .res_load_o(res_load), .out_load_o(out_load)
  );

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_opnd
      cu_opnd_reg #(.W(DATA_W)) i_opnd (
        .clk(clk), .rst_n(rst_n), .load_i(rd_take[i]),
        .d_i(src[i]), .q_o(opnd[i])
      );
      // R4
      opnd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take[i] |=> (opnd[i] == $past(src[i])));
    end
  endgenerate

  cu_alu #(.W(DATA_W), .LAT(ALU_LAT)) i_alu (
    .clk(clk), .rst_n(rst_n), .start_i(alu_start), .clear_i(alu_clear),
    .op_i(op_q), .a_i(opnd[0]), .b_i(opnd[1]),
    .res_o(alu_res), .vld_o(alu_vld)
  );

  always_comb begin
    op_nxt   = op_q;
    res_nxt  = res_q;
    data_nxt = data_o;
    if (op_load)  op_nxt   = cu_op_e'(op_i);
    if (res_load) res_nxt  = alu_res;
    if (out_load) data_nxt = res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_ADD;
      res_q  <= '0;
      data_o <= '0;
    end else begin
      op_q   <= op_nxt;
      res_q  <= res_nxt;
      data_o <= data_nxt;
    end
  end

  // R7
  wr_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gnt_i && wr_req_o && !kill_i) |=>
      (!wr_req_o && !busy_o && data_o == $past(res_q)));

  // R8
  kill_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_i && busy_o) |=>
      (!busy_o && rd_req_o == '0 && !wr_req_o && $stable(data_o)));

  // R9
  issue_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && busy_o) |=> $stable(op_q));

  // R11
  kill_idle_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_i && !busy_o && !issue_i) |=> (!busy_o && $stable(data_o)));
endmodule

// File: tb/test_opnd_result_cu.sv
module test_opnd_result_cu;
  logic        clk = 1'b0;
  logic        rst_n, issue, kill, wr_gnt, wr_req, busy;
  logic [1:0]  op, rd_gnt, rd_req;
  logic [15:0] src_a, src_b, data;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  opnd_result_cu i_opnd_result_cu (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .op_i(op), .kill_i(kill),
    .src_a_i(src_a), .src_b_i(src_b), .rd_gnt_i(rd_gnt), .wr_gnt_i(wr_gnt),
    .rd_req_o(rd_req), .wr_req_o(wr_req), .busy_o(busy), .data_o(data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic [15:0] ref_fn(input int o, input logic [15:0] a, input logic [15:0] b);
    case (o)
      0:       return a + b;
      1:       return a - b;
      2:       return a & b;
      default: return a ^ b;
    endcase
  endfunction

  // Starts and ends at a falling edge.
  task automatic run_op(input int o, input int d0, input int d1, input int dw,
                        input int kill_at, input bit spur);
    logic [15:0] ea = '0, eb = '0, prev;
    int  wc = 0;
    bit  done = 0, g0, g1, gw, k;
    prev  = data;
    issue = 1'b1;
    op    = 2'(o);
    @(negedge clk);
    issue = 1'b0;
    chk(busy == 1'b1, "R2 busy", busy, 1);
    chk(rd_req == 2'b11, "R2 rd_req", rd_req, 3);
    for (int c = 0; c < 80 && !done; c++) begin
      src_a = 16'($urandom);
      src_b = 16'($urandom);
      g0 = rd_req[0] && (c >= d0);
      g1 = rd_req[1] && (c >= d1);
      if (wr_req) wc++;
      gw = wr_req && (wc > dw);
      k  = (c == kill_at);
      rd_gnt = {g1, g0};
      wr_gnt = gw;
      kill   = k;
      if (spur && c == 1) begin
        issue = 1'b1;
        op    = 2'(o ^ 3);
      end
      if (g0) ea = src_a;
      if (g1) eb = src_b;
      @(negedge clk);
      issue = 1'b0; rd_gnt = '0; wr_gnt = 1'b0; kill = 1'b0;
      if (k) begin
        chk(!busy, "R8 busy", busy, 0);
        chk(rd_req == 2'b00, "R8 rd_req", rd_req, 0);
        chk(!wr_req, "R8 wr_req", wr_req, 0);
        chk(data == prev, "R8 data", data, prev);
        done = 1;
      end else begin
        if (g0) chk(!rd_req[0], "R5 rd_req[0]", rd_req[0], 0);
        if (g1) chk(!rd_req[1], "R5 rd_req[1]", rd_req[1], 0);
        if (wr_req) chk(rd_req == 2'b00, "R6 overlap", rd_req, 0);
        if (gw) begin
          chk(data == ref_fn(o, ea, eb), spur ? "R9 op kept" : "R4 R10 result",
              data, ref_fn(o, ea, eb));
          chk(!busy, "R7 busy", busy, 0);
          chk(!wr_req, "R7 wr_req", wr_req, 0);
          done = 1;
        end
      end
    end
    if (!done) chk(1'b0, "R7 no completion", 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    logic [15:0] hold;
    rst_n = 1'b0; issue = 1'b0; kill = 1'b0; op = '0;
    src_a = '0; src_b = '0; rd_gnt = '0; wr_gnt = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && rd_req == 2'b00 && !wr_req, "R1 ctrl", {busy, rd_req, wr_req}, 0);
    chk(data == 16'h0, "R1 data", data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: stray grants while idle
    for (int c = 0; c < 4; c++) begin
      rd_gnt = 2'(c); wr_gnt = c[0];
      @(negedge clk);
      chk(!busy && rd_req == 2'b00 && data == 16'h0, "R3 idle", {busy, rd_req}, 0);
    end
    rd_gnt = '0; wr_gnt = 1'b0;

    // R4 R10: sweep over ops and grant delays
    for (int o = 0; o < 4; o++)
      for (int d0 = 0; d0 < 3; d0++)
        for (int d1 = 0; d1 < 3; d1++)
          for (int dw = 0; dw < 3; dw++)
            run_op(o, d0, d1, dw, -1, 1'b0);

    // R8: kill swept over every phase
    for (int ka = 0; ka < 14; ka++) begin
      run_op(ka % 4, 1, 3, 2, ka, 1'b0);
      run_op((ka + 1) % 4, 0, 1, 0, -1, 1'b0);
    end

    // R9: issue while reading
    for (int o = 0; o < 4; o++) run_op(o, 3, 4, 1, -1, 1'b1);

    // R11: kill while idle
    hold = data;
    kill = 1'b1;
    @(negedge clk);
    kill = 1'b0;
    chk(!busy && rd_req == 2'b00 && !wr_req, "R11 ctrl", {busy, rd_req, wr_req}, 0);
    chk(data == hold, "R11 data", data, hold);
    run_op(1, 0, 0, 0, -1, 1'b0);

    report();
    $finish;
  end
endmodule